// File: doc/BRIEF.md
# Parallel Converter Bus Control Logic

This block is the digital side of an 8-bit converter that a host reads like a memory location. It decodes an active-low chip select together with active-low read and write strobes. A conversion of fixed length is timed by a cycle counter. When the conversion ends, the result goes into an output register. The block drives an active-low completion flag, a ready line that is modelled as a pull-low enable, an active-low over-range flag, and a data bus given as a value plus an output enable. The analog part is replaced by a parallel sample input and an over-range input. Both are captured when a conversion starts.

Two handshakes share the pins, and the `mode` input selects between them. In write-read mode (`mode` = 1) the host starts a conversion with the write strobe and later reads the result. In read mode (`mode` = 0) a single read strobe starts the conversion, and the bus stays undriven until the result is ready. In read mode the ready line tells the host to wait. Read mode is the mode chosen when the input is held low.

Top module: `adc_bus_ctrl`

## Requirements
- R1: During and after synchronous reset: `int_n` = 1, `rdy_drive_low` = 0, `ofl_n` = 1, `bus_oe` = 0, `bus_data` = 0.
- R2: A strobe counts only while `cs_n` is low. The effective read is `cs_n | rd_n` and the effective write is `cs_n | wr_n`. Toggling `rd_n` or `wr_n` with `cs_n` high starts nothing and does not enable the bus.
- R3: With `mode` = 1, a conversion starts at the clock edge that first sees the effective write go from 0 to 1. The captured value is loaded into `bus_data` when the conversion ends.
- R4: With `mode` = 0, a conversion starts at the clock edge that first sees the effective read go from 1 to 0. `bus_oe` stays 0 until the conversion ends and rises at the edge that loads the result.
- R5: The end of a conversion takes effect at exactly the CONV_CYCLES-th clock edge after the start edge.
- R6: `int_n` goes to 0 at the edge that ends a conversion. It returns to 1 at the edge that sees a rising effective read, or at a new start.
- R7: In read mode, `rdy_drive_low` goes to 1 at the edge that sees `cs_n` fall. It returns to 0 when a conversion ends, or when `cs_n` is high with no conversion running. In write-read mode a falling `cs_n` never asserts it.
- R8: If the captured over-range bit is 1, then at the end of the conversion `ofl_n` goes to 0 and `bus_data` reads all ones (8'hFF). If the bit is 0, `ofl_n` is 1 and the captured sample is loaded.
- R9: `bus_oe` is 1 only in the cycle after an edge that saw `cs_n` and `rd_n` both low, and only when no conversion is in progress at that edge. `ofl_n` has no enable.
- R10: The sample and over-range inputs are captured only at the start edge, so later changes do not affect the result. A start request while a conversion runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 1 = write-read handshake, 0 = read handshake |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sample_in | input | DATA_W | Value standing in for the converted input |
| over_in | input | 1 | Input above upper reference |
| bus_data | output | DATA_W | Output register value |
| bus_oe | output | 1 | Bus drive enable |
| int_n | output | 1 | Conversion complete, active low |
| rdy_drive_low | output | 1 | Pull ready line low |
| ofl_n | output | 1 | Over-range flag, active low |

## Verification
The hardest case to reach is a start request that arrives while a conversion is running, combined with input values that change after capture. The bench sends a second write pulse in the middle of a conversion and changes both the sample and the over-range input at the same time. It then checks that the first captured value appears exactly at the expected edge. Read-mode ready timing, overflow saturation, and strobes sent with chip select high are also driven directly. A behavioural model is compared against the outputs on every clock.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

  typedef enum logic {
    MODE_READ       = 1'b0,
    MODE_WRITE_READ = 1'b1
  } conv_mode_e;

  typedef struct packed {
    logic rd_fall;
    logic rd_rise;
    logic wr_rise;
    logic cs_fall;
    logic rd_low;
  } strobe_evt_t;

endpackage

// File: rtl/adc_strobe_decode.sv
module adc_strobe_decode
  import adc_bus_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  output strobe_evt_t evt
);

  logic rd_eff, wr_eff;
  logic rd_prev_q, wr_prev_q, cs_prev_q;

  // chip select gates both strobes
  assign rd_eff = cs_n | rd_n;
  assign wr_eff = cs_n | wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev_q <= 1'b1;
      wr_prev_q <= 1'b1;
      cs_prev_q <= 1'b1;
    end else begin
      rd_prev_q <= rd_eff;
      wr_prev_q <= wr_eff;
      cs_prev_q <= cs_n;
    end
  end

  always_comb begin
    evt.rd_fall = rd_prev_q & ~rd_eff;
    evt.rd_rise = ~rd_prev_q & rd_eff;
    evt.wr_rise = ~wr_prev_q & wr_eff;
    evt.cs_fall = cs_prev_q & ~cs_n;
    evt.rd_low  = ~rd_eff;
  end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LAST;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              load,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              over_in,
  output logic [DATA_W-1:0] data_q,
  output logic              ofl_n
);

  logic [DATA_W-1:0] cap_sample_q;
  logic              cap_over_q;
  logic [DATA_W-1:0] sat_value;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_sample_q <= '0;
      cap_over_q   <= 1'b0;
    end else if (capture) begin
      cap_sample_q <= sample_in;
      cap_over_q   <= over_in;
    end
  end

  // each bit forced high when the captured value was over range
  for (genvar b = 0; b < DATA_W; b++) begin : g_sat
    assign sat_value[b] = cap_sample_q[b] | cap_over_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ofl_n  <= 1'b1;
    end else if (load) begin
      data_q <= sat_value;
      ofl_n  <= ~cap_over_q;
    end
  end

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CONV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              over_in,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              int_n,
  output logic              rdy_drive_low,
  output logic              ofl_n
);

  strobe_evt_t evt;
  conv_mode_e  mode_sel;
  logic        conv_busy, conv_done, start_evt;

  assign mode_sel = conv_mode_e'(mode);

  adc_strobe_decode u_decode (
    .clk  (clk),
    .rst  (rst),
    .cs_n (cs_n),
    .rd_n (rd_n),
    .wr_n (wr_n),
    .evt  (evt)
  );

  // start event depends on the selected handshake; ignored while running
  assign start_evt = !conv_busy &&
                     ((mode_sel == MODE_WRITE_READ) ? evt.wr_rise : evt.rd_fall);

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start_evt),
    .busy  (conv_busy),
    .done  (conv_done)
  );

  adc_result_latch #(.DATA_W(DATA_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .capture   (start_evt),
    .load      (conv_done),
    .sample_in (sample_in),
    .over_in   (over_in),
    .data_q    (bus_data),
    .ofl_n     (ofl_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_n         <= 1'b1;
      rdy_drive_low <= 1'b0;
      bus_oe        <= 1'b0;
    end else begin
      if (conv_done)                       int_n <= 1'b0;
      else if (start_evt || evt.rd_rise)   int_n <= 1'b1;

      if (conv_done)                                         rdy_drive_low <= 1'b0;
      else if ((mode_sel == MODE_READ) && evt.cs_fall)       rdy_drive_low <= 1'b1;
      else if (cs_n && !conv_busy)                           rdy_drive_low <= 1'b0;

      bus_oe <= evt.rd_low && !start_evt && (!conv_busy || conv_done);
    end
  end

endmodule

// File: rtl/adc_bus_ctrl_checker.sv
module adc_bus_ctrl_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mode,
  input logic              cs_n,
  input logic              rd_n,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_oe,
  input logic              int_n,
  input logic              rdy_drive_low,
  input logic              ofl_n,
  input logic              busy,
  input logic              done,
  input logic              start_evt
);

  assert_bus_gate_R9: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(!cs_n && !rd_n));

  assert_no_drive_busy_R4: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !busy);

  assert_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    !ofl_n |-> (bus_data == {DATA_W{1'b1}}));

  assert_int_at_end_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(int_n) |-> $past(done));

  assert_rdy_mode_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_drive_low) |-> $past(!mode));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(done) |-> $stable(bus_data));

  assert_start_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_evt));

endmodule

bind adc_bus_ctrl adc_bus_ctrl_checker #(.DATA_W(DATA_W)) u_checker (
  .clk           (clk),
  .rst           (rst),
  .mode          (mode),
  .cs_n          (cs_n),
  .rd_n          (rd_n),
  .bus_data      (bus_data),
  .bus_oe        (bus_oe),
  .int_n         (int_n),
  .rdy_drive_low (rdy_drive_low),
  .ofl_n         (ofl_n),
  .busy          (conv_busy),
  .done          (conv_done),
  .start_evt     (start_evt)
);

// File: tb/adc_bus_ctrl_bench.sv
module adc_bus_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int W          = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         mode, cs_n, rd_n, wr_n, over_in;
  logic [W-1:0] sample_in;
  logic [W-1:0] bus_data;
  logic         bus_oe, int_n, rdy_drive_low, ofl_n;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_bus_ctrl #(.DATA_W(W), .CONV_CYCLES(N)) u_adc_bus_ctrl (
    .clk(clk), .rst(rst), .mode(mode), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .sample_in(sample_in), .over_in(over_in), .bus_data(bus_data),
    .bus_oe(bus_oe), .int_n(int_n), .rdy_drive_low(rdy_drive_low), .ofl_n(ofl_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // behavioural reference model
  int           m_cnt;
  bit           m_busy, m_int, m_rdy, m_ofl, m_oe, m_cap_o;
  bit           p_rd, p_wr, p_cs;
  logic [W-1:0] m_data, m_cap_s;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_int = 1; m_rdy = 0; m_ofl = 1; m_oe = 0;
      m_data = '0; m_cap_s = '0; m_cap_o = 0; p_rd = 1; p_wr = 1; p_cs = 1;
    end else begin
      bit rdx, wrx, rfall, rrise, wrise, cfall, st, fin;
      rdx   = cs_n | rd_n;
      wrx   = cs_n | wr_n;
      rfall = p_rd && !rdx;
      rrise = !p_rd && rdx;
      wrise = !p_wr && wrx;
      cfall = p_cs && !cs_n;
      st    = !m_busy && (mode ? wrise : rfall);
      fin   = m_busy && (m_cnt == 0);
      m_oe  = !rdx && !st && (!m_busy || fin);
      if (fin) begin
        m_data = m_cap_o ? '1 : m_cap_s;
        m_ofl  = !m_cap_o;
      end
      if (fin)                m_int = 0;
      else if (st || rrise)   m_int = 1;
      if (fin)                     m_rdy = 0;
      else if (!mode && cfall)     m_rdy = 1;
      else if (cs_n && !m_busy)    m_rdy = 0;
      if (st) begin
        m_busy = 1; m_cnt = N - 1; m_cap_s = sample_in; m_cap_o = over_in;
      end else if (m_busy) begin
        if (m_cnt == 0) m_busy = 0;
        else            m_cnt--;
      end
      p_rd = rdx; p_wr = wrx; p_cs = cs_n;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R9 bus_oe",      int'(bus_oe),        int'(m_oe));
      chk("R3 bus_data",    int'(bus_data),      int'(m_data));
      chk("R6 int_n",       int'(int_n),         int'(m_int));
      chk("R7 rdy",         int'(rdy_drive_low), int'(m_rdy));
      chk("R8 ofl_n",       int'(ofl_n),         int'(m_ofl));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; mode = 1; cs_n = 1; rd_n = 1; wr_n = 1; over_in = 0; sample_in = '0;
    tick(3);
    rst = 0;
    tick(1);
    // R1 reset state
    chk("R1 int_n", int'(int_n), 1);
    chk("R1 rdy", int'(rdy_drive_low), 0);
    chk("R1 ofl_n", int'(ofl_n), 1);
    chk("R1 bus_oe", int'(bus_oe), 0);
    chk("R1 bus_data", int'(bus_data), 0);

    // R2 strobes with chip select high
    wr_n = 0; tick(1); wr_n = 1; tick(N + 2);
    chk("R2 no start", int'(int_n), 1);
    rd_n = 0; tick(2);
    chk("R2 no drive", int'(bus_oe), 0);
    rd_n = 1; tick(1);

    // R3 R5 R10 write-read conversion with ignored restart
    sample_in = 8'h5A; cs_n = 0; wr_n = 0; tick(1);
    wr_n = 1; tick(1);
    sample_in = 8'h11; over_in = 1; wr_n = 0; tick(1);
    wr_n = 1; tick(N - 2);
    chk("R5 not yet done", int'(int_n), 1);
    tick(1);
    chk("R3 int low", int'(int_n), 0);
    chk("R10 captured", int'(bus_data), 8'h5A);
    chk("R8 no overflow", int'(ofl_n), 1);
    over_in = 0;
    rd_n = 0; tick(1);
    chk("R9 drive", int'(bus_oe), 1);
    rd_n = 1; tick(1);
    chk("R6 cleared by read", int'(int_n), 1);
    chk("R9 release", int'(bus_oe), 0);

    // R4 R7 read mode
    mode = 0; sample_in = 8'hC3; cs_n = 1; tick(2);
    cs_n = 0; rd_n = 0; tick(1);
    chk("R7 rdy asserted", int'(rdy_drive_low), 1);
    chk("R4 no drive at start", int'(bus_oe), 0);
    tick(N - 1);
    chk("R4 no drive busy", int'(bus_oe), 0);
    tick(1);
    chk("R4 drive at end", int'(bus_oe), 1);
    chk("R4 data", int'(bus_data), 8'hC3);
    chk("R7 rdy released", int'(rdy_drive_low), 0);
    rd_n = 1; cs_n = 1; tick(1);
    chk("R6 read rise", int'(int_n), 1);

    // R8 overflow then normal
    sample_in = 8'h12; over_in = 1; cs_n = 0; rd_n = 0; tick(N + 1);
    chk("R8 saturated", int'(bus_data), 8'hFF);
    chk("R8 flag", int'(ofl_n), 0);
    rd_n = 1; cs_n = 1; tick(1);
    over_in = 0; sample_in = 8'h07; mode = 1; cs_n = 0; wr_n = 0; tick(1);
    wr_n = 1; tick(N + 1);
    chk("R8 flag cleared", int'(ofl_n), 1);
    chk("R8 data", int'(bus_data), 8'h07);
    cs_n = 1; tick(1);

    // R7 write-read mode ignores chip select fall
    cs_n = 0; tick(2);
    chk("R7 no rdy", int'(rdy_drive_low), 0);

    // R6 new start clears completion flag
    wr_n = 0; tick(1); wr_n = 1; tick(1);
    chk("R6 start clears", int'(int_n), 1);
    tick(N + 1);
    cs_n = 1; tick(2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule